// File: doc/BRIEF.md
# Interrupt Condition Aggregator with Routing and Pacing

This block collects interrupt conditions from three event groups: 16 doorbell conditions, 8 message-queue conditions (one per descriptor queue) and 8 direct-I/O conditions. Every condition owns a status bit. Hardware sets the bit with a one-cycle event strobe, and software clears it by writing ones to a clear register.

A routing table gives each condition one of four physical interrupt outputs. Each output has its own pacing state machine, driven by a down-counter. The output issues a single one-cycle pulse when it is armed and at least one condition routed to it is pending. It then stays disarmed until software writes its rate register. That write reloads the counter, and the output re-arms when the counter reaches zero. Software must write the rate register even when no pacing is wanted: writing zero re-arms the output at once. A read-only decode register per output shows, for each event group, whether any condition routed there is pending.

Software reaches everything through a simple register bus. A write is a one-cycle strobe with address and data. A read is combinational from the address.

Each output's pacing machine has three states:
- ARMED: the counter is zero and the output may pulse.
- PACE: the counter is nonzero and counting down.
- SPENT: a pulse was issued and the output waits for a rate write.

Its transitions are:
- ARMED to SPENT when a routed condition is pending and no rate write occurs; the pulse is issued on this transition.
- Any state to PACE on a rate write with a nonzero value.
- Any state to ARMED on a rate write with value zero.
- PACE to ARMED when the counter steps from one to zero.
- PACE stays in PACE, decrementing, otherwise.

Top module: `irq_route_pace`

## Requirements
- R1: After reset all status bits, all routing fields and all decode registers read zero, every output is armed with a zero counter, and `irq_o` is low.
- R2: An event strobe sets its status bit, which reads back one cycle later: doorbell bits at address 0x00, message-queue bits at 0x01, direct-I/O bits at 0x02, with condition bit i at data bit i.
- R3: Writing ones to 0x04 (doorbell), 0x05 (message queue) or 0x06 (direct I/O) clears the matching status bits. Zero bits in the write leave their bits unchanged, and writes to the status addresses 0x00 to 0x02 change nothing.
- R4: When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Conditions are numbered doorbell 0 to 15, message queue 16 to 23, direct I/O 24 to 31. Condition c is routed by the 2-bit field at data bits 2*(c%16)+1 down to 2*(c%16) of the routing register at address 0x08 + c/16. These registers are writable and read back as written.
- R6: An armed output whose routed conditions become pending pulses in the cycle after the status bit is set. Outputs to which the condition is not routed do not pulse.
- R7: A pulse lasts exactly one cycle. The output is then disarmed, and newly pending conditions issue no further pulse until its rate register is written.
- R8: Writing value v to the rate register of output d (address 0x10 + d) reloads its counter. If a routed condition is pending, the pulse appears v+1 cycles after the write edge; v = 0 therefore re-arms immediately.
- R9: A rate write while the counter is still running restarts the count from the new value.
- R10: The decode register of output d (address 0x18 + d) shows in bit 0 any pending doorbell condition routed to d, in bit 1 any pending message-queue condition and in bit 2 any pending direct-I/O condition.
- R11: Reads of addresses not listed above, including the clear and rate addresses, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_evt_i | input | 16 | Doorbell condition set strobes |
| mq_evt_i | input | 8 | Message-queue condition set strobes |
| dio_evt_i | input | 8 | Direct-I/O condition set strobes |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 4 | Physical interrupt pulses, one per destination |

## Verification
The assertions check the following on every cycle:
- set wins over clear;
- clears take effect;
- pulses are one cycle wide;
- a pulse is always preceded by a pending routed condition;
- an output in PACE or SPENT never pulses in the next cycle.

Only the bench's scenarios can show the rest. These are the exact pulse cycle after a rate write, a reload during counting, the routing of every condition to every output, the decode grouping, and the field layout of the routing registers.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    typedef enum logic [1:0] {
        DST_ARMED = 2'd0,
        DST_PACE  = 2'd1,
        DST_SPENT = 2'd2
    } dst_state_e;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] ADR_STAT_DB  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_STAT_MQ  = 6'h01;
    localparam logic [ADDR_W-1:0] ADR_STAT_DIO = 6'h02;
    localparam logic [ADDR_W-1:0] ADR_CLR_DB   = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_CLR_MQ   = 6'h05;
    localparam logic [ADDR_W-1:0] ADR_CLR_DIO  = 6'h06;
    localparam logic [ADDR_W-1:0] ADR_ROUTE    = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_RATE     = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_DECODE   = 6'h18;

    localparam int N_GRP = 3;
endpackage

// File: rtl/irqr_status_bank.sv
module irqr_status_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | set_i;
    end

    assign status_o = status_q;

    // R4: a strobed bit is set in the next cycle even if cleared at the same time
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R3: a clear with no coincident set drops the bit
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((status_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irqr_router.sv
module irqr_router
    import irqr_pkg::*;
#(
    parameter int N_DB   = 16,
    parameter int N_MQ   = 8,
    parameter int N_DIO  = 8,
    parameter int N_DEST = 4,
    parameter int DW     = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [((N_DB+N_MQ+N_DIO)+(DW/$clog2(N_DEST))-1)/(DW/$clog2(N_DEST))-1:0] route_we_i,
    input  logic [DW-1:0]                        wdata_i,
    input  logic [N_DB+N_MQ+N_DIO-1:0]           status_i,
    output logic [((N_DB+N_MQ+N_DIO)+(DW/$clog2(N_DEST))-1)/(DW/$clog2(N_DEST))-1:0][DW-1:0] route_rd_o,
    output logic [N_DEST-1:0][N_GRP-1:0]         pend_o
);
    localparam int N_COND = N_DB + N_MQ + N_DIO;
    localparam int DEST_W = $clog2(N_DEST);
    localparam int SLOTS  = DW / DEST_W;

    logic [N_COND-1:0][DEST_W-1:0] route_q;

    for (genvar c = 0; c < N_COND; c++) begin : g_route
        localparam int RI = c / SLOTS;
        localparam int SI = c % SLOTS;
        always_ff @(posedge clk) begin
            if (!rst_n)               route_q[c] <= '0;
            else if (route_we_i[RI])  route_q[c] <= wdata_i[SI*DEST_W +: DEST_W];
        end
    end

    always_comb begin
        route_rd_o = '0;
        for (int c = 0; c < N_COND; c++) begin
            route_rd_o[c/SLOTS][(c%SLOTS)*DEST_W +: DEST_W] = route_q[c];
        end
    end

    always_comb begin
        pend_o = '0;
        for (int d = 0; d < N_DEST; d++) begin
            for (int c = 0; c < N_COND; c++) begin
                if (status_i[c] && (route_q[c] == DEST_W'(d))) begin
                    if (c < N_DB)             pend_o[d][0] = 1'b1;
                    else if (c < N_DB + N_MQ) pend_o[d][1] = 1'b1;
                    else                      pend_o[d][2] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irqr_pacer.sv
module irqr_pacer
    import irqr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             pend_any_i,
    output logic             irq_o
);
    dst_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             fire, irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DST_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        fire    = 1'b0;
        if (load_i) begin
            cnt_n   = load_val_i;
            state_n = (load_val_i == '0) ? DST_ARMED : DST_PACE;
        end else begin
            unique case (state_q)
                DST_ARMED: begin
                    if (pend_any_i) begin
                        fire    = 1'b1;
                        state_n = DST_SPENT;
                    end
                end
                DST_PACE: begin
                    cnt_n = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_n = DST_ARMED;
                end
                DST_SPENT: state_n = DST_SPENT;
                default:   state_n = DST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign irq_o = irq_q;

    // R7: pulse is a single cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6: a pulse always follows a pending routed condition
    a_r6_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(pend_any_i));

    // R8: no pulse while the pacing counter runs
    a_r8_counting_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DST_PACE) |=> !irq_q);

    // R7: a disarmed output stays quiet
    a_r7_spent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DST_SPENT) |=> !irq_q);
endmodule

// File: rtl/irq_route_pace.sv
module irq_route_pace
    import irqr_pkg::*;
#(
    parameter int N_DB   = 16,
    parameter int N_MQ   = 8,
    parameter int N_DIO  = 8,
    parameter int N_DEST = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DB-1:0]   db_evt_i,
    input  logic [N_MQ-1:0]   mq_evt_i,
    input  logic [N_DIO-1:0]  dio_evt_i,
    input  logic              bus_we_i,
    input  logic [5:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [N_DEST-1:0] irq_o
);
    localparam int DW     = 32;
    localparam int N_COND = N_DB + N_MQ + N_DIO;
    localparam int DEST_W = $clog2(N_DEST);
    localparam int SLOTS  = DW / DEST_W;
    localparam int N_RREG = (N_COND + SLOTS - 1) / SLOTS;

    logic [N_DB-1:0]  db_stat, db_clr;
    logic [N_MQ-1:0]  mq_stat, mq_clr;
    logic [N_DIO-1:0] dio_stat, dio_clr;

    assign db_clr  = (bus_we_i && bus_addr_i == ADR_CLR_DB)  ? bus_wdata_i[N_DB-1:0]  : '0;
    assign mq_clr  = (bus_we_i && bus_addr_i == ADR_CLR_MQ)  ? bus_wdata_i[N_MQ-1:0]  : '0;
    assign dio_clr = (bus_we_i && bus_addr_i == ADR_CLR_DIO) ? bus_wdata_i[N_DIO-1:0] : '0;

    irqr_status_bank #(.W(N_DB)) u_db (
        .clk(clk), .rst_n(rst_n), .set_i(db_evt_i), .clr_i(db_clr), .status_o(db_stat));
    irqr_status_bank #(.W(N_MQ)) u_mq (
        .clk(clk), .rst_n(rst_n), .set_i(mq_evt_i), .clr_i(mq_clr), .status_o(mq_stat));
    irqr_status_bank #(.W(N_DIO)) u_dio (
        .clk(clk), .rst_n(rst_n), .set_i(dio_evt_i), .clr_i(dio_clr), .status_o(dio_stat));

    logic [N_RREG-1:0]           route_we;
    logic [N_RREG-1:0][DW-1:0]   route_rd;
    logic [N_DEST-1:0][N_GRP-1:0] pend;

    for (genvar r = 0; r < N_RREG; r++) begin : g_rwe
        assign route_we[r] = bus_we_i && (bus_addr_i == ADR_ROUTE + 6'(r));
    end

    irqr_router #(
        .N_DB(N_DB), .N_MQ(N_MQ), .N_DIO(N_DIO), .N_DEST(N_DEST), .DW(DW)
    ) u_router (
        .clk(clk), .rst_n(rst_n), .route_we_i(route_we), .wdata_i(bus_wdata_i),
        .status_i({dio_stat, mq_stat, db_stat}), .route_rd_o(route_rd), .pend_o(pend));

    for (genvar d = 0; d < N_DEST; d++) begin : g_dest
        logic load;
        assign load = bus_we_i && (bus_addr_i == ADR_RATE + 6'(d));
        irqr_pacer #(.CNT_W(CNT_W)) u_pacer (
            .clk(clk), .rst_n(rst_n), .load_i(load),
            .load_val_i(bus_wdata_i[CNT_W-1:0]),
            .pend_any_i(|pend[d]), .irq_o(irq_o[d]));
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADR_STAT_DB)       bus_rdata_o[N_DB-1:0]  = db_stat;
        else if (bus_addr_i == ADR_STAT_MQ)  bus_rdata_o[N_MQ-1:0]  = mq_stat;
        else if (bus_addr_i == ADR_STAT_DIO) bus_rdata_o[N_DIO-1:0] = dio_stat;
        else begin
            for (int r = 0; r < N_RREG; r++)
                if (bus_addr_i == ADR_ROUTE + 6'(r)) bus_rdata_o = route_rd[r];
            for (int d = 0; d < N_DEST; d++)
                if (bus_addr_i == ADR_DECODE + 6'(d)) bus_rdata_o[N_GRP-1:0] = pend[d];
        end
    end
endmodule

// File: tb/tb_irq_route_pace.sv
`timescale 1ns/1ps
module tb_irq_route_pace;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] db_evt = '0;
    logic [7:0]  mq_evt = '0;
    logic [7:0]  dio_evt = '0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] rt [32];

    irq_route_pace dut (
        .clk(clk), .rst_n(rst_n), .db_evt_i(db_evt), .mq_evt_i(mq_evt), .dio_evt_i(dio_evt),
        .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq));

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic fire(int c);
        @(negedge clk);
        if (c < 16)      db_evt  = 16'(1 << c);
        else if (c < 24) mq_evt  = 8'(1 << (c - 16));
        else             dio_evt = 8'(1 << (c - 24));
        @(negedge clk);
        db_evt = '0; mq_evt = '0; dio_evt = '0;
    endtask

    function automatic logic [31:0] rreg(int r);
        logic [31:0] v = '0;
        for (int s = 0; s < 16; s++) v[s*2 +: 2] = rt[r*16 + s];
        return v;
    endfunction

    task automatic route(int c, int d);
        rt[c] = 2'(d);
        wr(6'h08 + 6'(c / 16), rreg(c / 16));
    endtask

    task automatic rearm_all();
        for (int d = 0; d < 4; d++) wr(6'h10 + 6'(d), 32'd0);
    endtask

    task automatic clear_all();
        wr(6'h04, 32'hFFFF); wr(6'h05, 32'hFF); wr(6'h06, 32'hFF);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < 32; c++) rt[c] = 2'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        for (int a = 0; a < 3; a++) begin rd(6'(a), v); chk("R1 status", v, 0); end
        for (int a = 8; a < 10; a++) begin rd(6'(a), v); chk("R1 route", v, 0); end
        for (int a = 24; a < 28; a++) begin rd(6'(a), v); chk("R1 decode", v, 0); end

        // R11 unmapped and write-only addresses read zero
        rd(6'h03, v); chk("R11 hole", v, 0);
        rd(6'h3F, v); chk("R11 top", v, 0);
        wr(6'h10, 32'd0);
        rd(6'h10, v); chk("R11 rate read", v, 0);
        rd(6'h04, v); chk("R11 clear read", v, 0);

        // R5 routing register readback and field layout
        wr(6'h08, 32'hA5C3_1E77); wr(6'h09, 32'h1234_5678);
        rd(6'h08, v); chk("R5 route0", v, 32'hA5C3_1E77);
        rd(6'h09, v); chk("R5 route1", v, 32'h1234_5678);
        wr(6'h08, 32'h0); wr(6'h09, 32'h0);

        // R2 R6 R10 R3: every condition to every destination
        for (int c = 0; c < 32; c++) begin
            for (int d = 0; d < 4; d++) begin
                int g;
                int b;
                g = (c < 16) ? 0 : (c < 24) ? 1 : 2;
                b = (c < 16) ? c : (c < 24) ? c - 16 : c - 24;
                route(c, d);
                rearm_all();
                fire(c);
                chk("R6 no early pulse", 32'(irq), 0);
                rd(6'(g), v); chk("R2 status set", v, 32'(1) << b);
                @(negedge clk);
                chk("R6 routed pulse", 32'(irq), 32'(1) << d);
                for (int e = 0; e < 4; e++) begin
                    rd(6'h18 + 6'(e), v);
                    chk("R10 decode", v, (e == d) ? (32'(1) << g) : 0);
                end
                @(negedge clk);
                chk("R7 pulse width", 32'(irq), 0);
                wr(6'h04 + 6'(g), 32'(1) << b);
                rd(6'(g), v); chk("R3 cleared", v, 0);
            end
        end
        for (int c = 0; c < 32; c++) rt[c] = 2'd0;
        wr(6'h08, 0); wr(6'h09, 0);
        rearm_all();

        // R3 writes to status addresses and zero bits are ignored
        fire(3);
        wr(6'h00, 32'h0000_FFFF);
        rd(6'h00, v); chk("R3 status write ignored", v, 32'h8);
        wr(6'h04, 32'h0000_FFF7);
        rd(6'h00, v); chk("R3 zero bit kept", v, 32'h8);
        wr(6'h04, 32'h8);
        rd(6'h00, v); chk("R3 one bit cleared", v, 0);

        // R4 set and clear in the same cycle
        fire(18);
        @(negedge clk);
        mq_evt = 8'h04; bus_we = 1'b1; bus_addr = 6'h05; bus_wdata = 32'h04;
        wr(6'h05, 32'h04);
        @(negedge clk);
        mq_evt = 8'h04; bus_we = 1'b1; bus_addr = 6'h05; bus_wdata = 32'h04;
        @(negedge clk);
        mq_evt = 8'h00; bus_we = 1'b0;
        rd(6'h01, v); chk("R4 set wins", v, 32'h04);
        clear_all();
        rearm_all();

        // R8 pacing sweep per destination and load value
        for (int d = 0; d < 4; d++) begin
            route(24, d);
            rearm_all();
            fire(24);
            @(negedge clk);
            chk("R8 initial pulse", 32'(irq), 32'(1) << d);
            for (int val = 0; val < 6; val++) begin
                wr(6'h10 + 6'(d), 32'(val));
                for (int k = 0; k <= val + 3; k++) begin
                    chk("R8 paced pulse", 32'(irq), (k == val + 1) ? (32'(1) << d) : 0);
                    @(negedge clk);
                end
            end
            clear_all();
        end
        rearm_all();

        // R7 disarmed until rate write
        route(5, 1); route(6, 1); route(7, 1);
        rearm_all();
        fire(5);
        @(negedge clk);
        chk("R7 first pulse", 32'(irq), 32'h2);
        fire(6);
        for (int k = 0; k < 10; k++) begin
            chk("R7 stays disarmed", 32'(irq), 0);
            @(negedge clk);
        end
        clear_all();
        wr(6'h11, 32'd0);
        for (int k = 0; k < 3; k++) begin
            chk("R7 rearm no pending", 32'(irq), 0);
            @(negedge clk);
        end
        fire(7);
        @(negedge clk);
        chk("R7 pulse after rearm", 32'(irq), 32'h2);
        clear_all();

        // R9 reload during counting
        route(16, 2);
        rearm_all();
        fire(16);
        @(negedge clk);
        chk("R9 initial pulse", 32'(irq), 32'h4);
        wr(6'h12, 32'd10);
        for (int k = 0; k < 3; k++) begin
            chk("R9 counting", 32'(irq), 0);
            @(negedge clk);
        end
        wr(6'h12, 32'd4);
        for (int k = 0; k <= 7; k++) begin
            chk("R9 reloaded pulse", 32'(irq), (k == 5) ? 32'h4 : 0);
            @(negedge clk);
        end
        clear_all();

        summary();
    end
endmodule